// File: doc/BRIEF.md
# Sleep and Wake Power Mode Controller

This block decides whether the device runs in normal mode or in sleep. Two sources can request sleep. The first is a sticky software shutdown flag. A strobe to a dedicated sleep address sets it, and so does a configuration write that carries a 1. A configuration write that carries a 0 clears it, and so does a wake event. The second source is a level on a pin that has been given the sleep function. A polarity select decides whether the high level or the low level means sleep. The pin request passes through a short synchronizer.

The sleep state is the OR of the two sources, so the pin overrides every software write and every wake event. The pin never alters the shutdown flag, so releasing the pin returns to normal mode only when the flag is already clear. The serial interface and the data registers stay reachable during sleep, because only the sleep state output gates the other blocks.

The block also holds back the clock outputs after power-on. It enables them only once the supply supervisor has reported good for a fixed number of consecutive cycles. If the supervisor drops, the count starts again.

Top module: `pwr_mode_ctl`

## Requirements
- R1: After reset, sleep_st, shdn_rb and clk_out_en are all 0.
- R2: A cycle with sleep_addr_wr high sets shdn_rb to 1 at the next clock edge.
- R3: A cycle with cfg_wr high sets shdn_rb when cfg_sleep_bit is 1 and clears it when cfg_sleep_bit is 0. A set from either source wins over a clear in the same cycle.
- R4: A cycle with wake_evt high clears shdn_rb at the next edge, unless a set occurs in the same cycle.
- R5: The pin requests sleep when pin_sleep_in equals pin_pol (pin_pol=1: a high level means sleep; pin_pol=0: a low level means sleep). The request reaches sleep_st after SYNC_STAGES clock edges.
- R6: sleep_st is the OR of the synchronized pin request and shdn_rb. A change on the pin never changes shdn_rb.
- R7: While the pin request is active, sleep_st stays 1 through wake events and clearing writes. Releasing the pin returns sleep_st to 0 only if shdn_rb is 0.
- R8: clk_out_en rises at the TIMEOUT-th consecutive clock edge with sup_good high, and not before.
- R9: A clock edge with sup_good low drives clk_out_en to 0 and restarts the timeout count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sleep_addr_wr | input | 1 | Write strobe to the dedicated sleep address |
| cfg_wr | input | 1 | Write strobe to the sleep configuration bit |
| cfg_sleep_bit | input | 1 | Data bit for the configuration write |
| pin_sleep_in | input | 1 | Raw level of the pin carrying the sleep function |
| pin_pol | input | 1 | Pin polarity: 1 = high means sleep, 0 = low means sleep |
| wake_evt | input | 1 | Wake-up event pulse |
| sup_good | input | 1 | Supply supervisor reports good |
| sleep_st | output | 1 | Current sleep state |
| shdn_rb | output | 1 | Readback of the shutdown flag |
| clk_out_en | output | 1 | Enable for the clock outputs |

## Verification
A table of single-cycle write and wake combinations drives the shutdown flag through setting, holding and clearing, with the pin inactive. It includes the collisions where a set and a clear arrive together, which separate set-wins priority from last-write or clear-wins behaviour. Directed sequences then assert the pin in both polarities, with wake events, clearing writes and set writes applied while the pin is held. These show whether the pin overrides software and whether it leaves the flag untouched. The supervisor sequence samples clk_out_en one edge before the timeout and at the timeout, then drops sup_good for one cycle. That exposes off-by-one counts and a count that fails to restart.

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl #(
  parameter int TIMEOUT     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep_addr_wr,
  input  logic cfg_wr,
  input  logic cfg_sleep_bit,
  input  logic pin_sleep_in,
  input  logic pin_pol,
  input  logic wake_evt,
  input  logic sup_good,
  output logic sleep_st,
  output logic shdn_rb,
  output logic clk_out_en
);

  localparam int CW = $clog2(TIMEOUT + 1);
  localparam logic [CW-1:0] LIM = CW'(TIMEOUT);

  logic                   pin_raw_req;
  logic [SYNC_STAGES-1:0] pin_sync;
  logic                   pin_req;
  logic                   shdn_set, shdn_clr;
  logic                   shdn_q;
  logic [CW-1:0]          cnt;

  assign pin_raw_req = (pin_sleep_in == pin_pol);

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pin_sync <= '0;
        else        pin_sync <= pin_raw_req;
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pin_sync <= '0;
        else        pin_sync <= {pin_sync[SYNC_STAGES-2:0], pin_raw_req};
    end
  endgenerate

  assign pin_req  = pin_sync[SYNC_STAGES-1];
  assign shdn_set = sleep_addr_wr | (cfg_wr & cfg_sleep_bit);
  assign shdn_clr = wake_evt | (cfg_wr & ~cfg_sleep_bit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        shdn_q <= 1'b0;
    else if (shdn_set) shdn_q <= 1'b1;
    else if (shdn_clr) shdn_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (!sup_good)  cnt <= '0;
    else if (cnt != LIM) cnt <= cnt + 1'b1;
  end

  assign shdn_rb    = shdn_q;
  assign sleep_st   = pin_req | shdn_q;
  assign clk_out_en = (cnt == LIM);

endmodule

// File: rtl/pwr_mode_ctl_chk.sv
module pwr_mode_ctl_chk #(
  parameter int TIMEOUT = 16
) (
  input logic clk,
  input logic rst_n,
  input logic sleep_addr_wr,
  input logic cfg_wr,
  input logic cfg_sleep_bit,
  input logic wake_evt,
  input logic sup_good,
  input logic sleep_st,
  input logic shdn_rb,
  input logic clk_out_en
);

  localparam int RW = $clog2(TIMEOUT + 1);
  logic [RW-1:0] good_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        good_run <= '0;
    else if (!sup_good)                good_run <= '0;
    else if (good_run != RW'(TIMEOUT)) good_run <= good_run + 1'b1;
  end

  p_addr_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_addr_wr |=> shdn_rb);

  p_cfg_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_sleep_bit) |=> shdn_rb);

  p_wake_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_evt && !sleep_addr_wr && !cfg_wr) |=> !shdn_rb);

  p_flag_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sleep_addr_wr && !cfg_wr && !wake_evt) |=> $stable(shdn_rb));

  p_flag_sleeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    shdn_rb |-> sleep_st);

  p_en_after_timeout_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clk_out_en |-> (good_run == RW'(TIMEOUT)));

  p_en_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sup_good |=> !clk_out_en);

endmodule

bind pwr_mode_ctl pwr_mode_ctl_chk #(.TIMEOUT(TIMEOUT)) i_chk (
  .clk(clk), .rst_n(rst_n), .sleep_addr_wr(sleep_addr_wr), .cfg_wr(cfg_wr),
  .cfg_sleep_bit(cfg_sleep_bit), .wake_evt(wake_evt), .sup_good(sup_good),
  .sleep_st(sleep_st), .shdn_rb(shdn_rb), .clk_out_en(clk_out_en)
);

// File: tb/test_pwr_mode_ctl.sv
module test_pwr_mode_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int TO = 6;
  localparam int SYNC = 2;
  localparam int NVEC = 10;
  // {addr_wr, cfg_wr, cfg_bit, wake, expected flag}
  localparam logic [4:0] VEC [NVEC] = '{
    5'b1_0_0_0_1, 5'b0_0_0_0_1, 5'b0_0_0_1_0, 5'b0_1_1_0_1, 5'b0_1_0_0_0,
    5'b0_1_0_1_0, 5'b1_1_0_0_1, 5'b1_0_0_1_1, 5'b0_1_1_1_1, 5'b0_0_0_1_0
  };

  logic clk = 0, rst_n = 0;
  logic sleep_addr_wr = 0, cfg_wr = 0, cfg_sleep_bit = 0;
  logic pin_sleep_in = 0, pin_pol = 1, wake_evt = 0, sup_good = 0;
  logic sleep_st, shdn_rb, clk_out_en;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_mode_ctl #(.TIMEOUT(TO), .SYNC_STAGES(SYNC)) i_pwr_mode_ctl (
    .clk(clk), .rst_n(rst_n), .sleep_addr_wr(sleep_addr_wr), .cfg_wr(cfg_wr),
    .cfg_sleep_bit(cfg_sleep_bit), .pin_sleep_in(pin_sleep_in), .pin_pol(pin_pol),
    .wake_evt(wake_evt), .sup_good(sup_good), .sleep_st(sleep_st),
    .shdn_rb(shdn_rb), .clk_out_en(clk_out_en));

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic pulse(input logic a, input logic cw, input logic cb, input logic w);
    sleep_addr_wr = a; cfg_wr = cw; cfg_sleep_bit = cb; wake_evt = w;
    step(1);
    sleep_addr_wr = 0; cfg_wr = 0; cfg_sleep_bit = 0; wake_evt = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++; checks++;
    $display("FAIL watchdog actual=hang expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(2);
    chk("R1 sleep_st", sleep_st, 1'b0);
    chk("R1 shdn_rb", shdn_rb, 1'b0);
    chk("R1 clk_out_en", clk_out_en, 1'b0);
    rst_n = 1;
    step(1);
    chk("R1 sleep_st after release", sleep_st, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      pulse(VEC[i][4], VEC[i][3], VEC[i][2], VEC[i][1]);
      chk($sformatf("R2/R3/R4 vec%0d shdn", i), shdn_rb, VEC[i][0]);
      chk($sformatf("R6 vec%0d sleep", i), sleep_st, VEC[i][0]);
    end

    // R5 active-high pin, R6 flag untouched
    pin_pol = 1; pin_sleep_in = 1;
    step(SYNC - 1);
    chk("R5 not yet synced", sleep_st, 1'b0);
    step(1);
    chk("R5 high-active sleep", sleep_st, 1'b1);
    chk("R6 pin leaves flag", shdn_rb, 1'b0);
    // R7 override of wake and clearing write
    pulse(0, 0, 0, 1);
    chk("R7 wake under pin", sleep_st, 1'b1);
    pulse(0, 1, 0, 0);
    chk("R7 clear write under pin", sleep_st, 1'b1);
    pulse(1, 0, 0, 0);
    chk("R6 set under pin", shdn_rb, 1'b1);
    pin_sleep_in = 0;
    step(SYNC + 1);
    chk("R7 release with flag set", sleep_st, 1'b1);
    pulse(0, 0, 0, 1);
    chk("R7 wake after release", sleep_st, 1'b0);
    // R5 active-low pin
    pin_pol = 0; pin_sleep_in = 1;
    step(SYNC + 1);
    chk("R5 low-active idle high", sleep_st, 1'b0);
    pin_sleep_in = 0;
    step(SYNC);
    chk("R5 low-active sleep", sleep_st, 1'b1);
    chk("R6 low pin leaves flag", shdn_rb, 1'b0);
    pin_sleep_in = 1;
    step(SYNC);
    chk("R7 release flag clear", sleep_st, 1'b0);

    // R8 / R9 timeout
    sup_good = 1;
    step(TO - 1);
    chk("R8 before timeout", clk_out_en, 1'b0);
    step(1);
    chk("R8 at timeout", clk_out_en, 1'b1);
    step(3);
    chk("R8 holds", clk_out_en, 1'b1);
    sup_good = 0;
    step(1);
    chk("R9 drop", clk_out_en, 1'b0);
    sup_good = 1;
    step(TO - 1);
    chk("R9 restart count", clk_out_en, 1'b0);
    step(1);
    chk("R9 re-enable", clk_out_en, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule